// File: doc/BRIEF.md
# Multiplicity and Energy Trigger

This block makes the trigger decision for one detector module that is read out through many photomultiplier channels. Each clock cycle, every channel presents a discriminator hit flag and a digitized charge. The block keeps a sliding window of the most recent cycles. Over that window it counts how many distinct channels fired and sums the charge those hits carried. A physics trigger is raised when either total is strictly above a threshold that software can program. Each of the two criteria can be switched off on its own.

Besides the physics decision, the block accepts LED, radioactive-source and muon trigger requests, and it has a built-in periodic trigger with a programmable period. Every accepted trigger is a one-cycle pulse that carries a type mask with one bit per source. Sources that fire together are reported in the same pulse. A programmable holdoff after each pulse suppresses repeats while one event is still inside the window. When built as a veto trigger, the block also fires when any plane of a plane-organized detector holds more than a fixed number of hits in the window.

Top module: `mtrig_top`

## Requirements
- R1: When the multiplicity criterion is enabled (control bit 0), a trigger is raised when the number of distinct channels hit inside the window is strictly greater than the multiplicity threshold (register address 1, reset value 15). A count of exactly 15 does not trigger.
- R2: When the charge criterion is enabled (control bit 1), a trigger is raised when the sum of the charge of hit channels over the window is strictly greater than the charge threshold (address 2, reset 15). The charge of a channel counts only in a cycle where its hit flag is set.
- R3: A channel that fires in several cycles of one window counts once toward multiplicity.
- R4: The window spans WIN cycles (4 by default). Hits presented 3 cycles apart combine, and hits presented 4 cycles apart do not. The same holds for charge.
- R5: A condition presented at rising edge k makes trig_o high during the cycle after rising edge k+2. LED, source and muon requests use the same latency.
- R6: type_o is a mask with bit 0 for physics, bit 1 for LED, bit 2 for source, bit 3 for periodic and bit 4 for muon. Sources that meet in one cycle all appear in a single pulse. type_o is zero whenever trig_o is low.
- R7: With the periodic enable set (control bit 4, reset 0) and a period P (address 3), the first periodic pulse comes P+1 edges after the edge that writes the enable, and later pulses follow every P cycles.
- R8: Each trigger is a single-cycle pulse. It is followed by a holdoff of max(H, WIN) cycles, where H is at address 4 (reset WIN). Every request that would fire inside the holdoff is dropped.
- R9: A source or criterion whose enable bit is clear raises no trigger. The enable bits are bit 2 for LED, bit 3 for source and bit 5 for muon. The control register resets to 0x2F.
- R10: In veto configuration (VETO=1), a trigger with type bit 0 is raised when any plane of PLANE_SZ channels has more than PLANE_MIN (2) distinct hits in the window. This criterion is gated by the multiplicity enable.
- R11: After reset, trig_o and type_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NCH | Per-channel discriminator hit flags |
| charge_i | input | NCH*CW | Per-channel digitized charge, channel c at bits c*CW +: CW |
| led_req_i | input | 1 | LED trigger request |
| src_req_i | input | 1 | Radioactive-source trigger request |
| muon_req_i | input | 1 | Muon trigger request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | DW | Configuration write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| type_o | output | 5 | Trigger type mask |

## Verification
A stimulus driven in the low half of cycle n is sampled at the next edge. The resulting physics, LED, source or muon pulse is therefore due at the sample in cycle n+3. A periodic pulse is due P+2 cycles after the enable write is driven. The driver pushes each expected pulse with its exact due cycle into a queue. The monitor flags any pulse that has no matching entry, any mask that differs, and any entry whose cycle passes without a pulse. For the dropped-request and disabled-source cases, a quiet window is sampled directly at the trigger output.

// File: rtl/mtrig_pkg.sv
package mtrig_pkg;
   localparam int TYPE_W = 5;
   localparam int TB_PHYS = 0;
   localparam int TB_LED  = 1;
   localparam int TB_SRC  = 2;
   localparam int TB_PER  = 3;
   localparam int TB_MUON = 4;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_MTHR = 3'd1;
   localparam logic [ADDR_W-1:0] A_QTHR = 3'd2;
   localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
   localparam logic [ADDR_W-1:0] A_HOLD = 3'd4;

   // control word, bit 0 is the LSB field (mult)
   typedef struct packed {
      logic muon;
      logic per;
      logic src;
      logic led;
      logic chg;
      logic mult;
   } ctrl_t;

   localparam int CTRL_W = 6;
   localparam ctrl_t CTRL_RST = 6'h2F;
endpackage

// File: rtl/mtrig_cfg.sv
module mtrig_cfg
   import mtrig_pkg::*;
#(
   parameter int DW       = 32,
   parameter int CNT_W    = 9,
   parameter int QSUM_W   = 20,
   parameter int PER_W    = 16,
   parameter int HOLD_W   = 8,
   parameter int MTHR_RST = 15,
   parameter int QTHR_RST = 15,
   parameter int PER_RST  = 1000,
   parameter int HOLD_RST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  mthr_o,
   output logic [QSUM_W-1:0] qthr_o,
   output logic [PER_W-1:0]  per_o,
   output logic [HOLD_W-1:0] hold_o
);
   if (DW < QSUM_W || DW < PER_W || DW < HOLD_W || DW < CNT_W || DW < CTRL_W) begin : g_bad_dw
      $error("mtrig_cfg: DW narrower than a register field");
   end

   wire unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= CTRL_RST;
         mthr_o <= CNT_W'(MTHR_RST);
         qthr_o <= QSUM_W'(QTHR_RST);
         per_o  <= PER_W'(PER_RST);
         hold_o <= HOLD_W'(HOLD_RST);
      end else if (we_i) begin
         case (addr_i)
            A_CTRL:  ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            A_MTHR:  mthr_o <= wdata_i[CNT_W-1:0];
            A_QTHR:  qthr_o <= wdata_i[QSUM_W-1:0];
            A_PER:   per_o  <= wdata_i[PER_W-1:0];
            A_HOLD:  hold_o <= wdata_i[HOLD_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mtrig_window.sv
module mtrig_window #(
   parameter int NCH       = 256,
   parameter int CW        = 8,
   parameter int WIN       = 4,
   parameter int CNT_W     = 9,
   parameter int CSUM_W    = 17,
   parameter int QSUM_W    = 20,
   parameter bit VETO      = 1'b0,
   parameter int PLANE_SZ  = 16,
   parameter int PLANE_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    hit_i,
   input  logic [NCH*CW-1:0] chg_i,
   output logic [CNT_W-1:0]  mult_o,
   output logic [QSUM_W-1:0] qwin_o,
   output logic              plane_o
);
   localparam int QMAX = WIN * NCH * ((1 << CW) - 1);

   logic [NCH-1:0]    act;
   logic [CNT_W-1:0]  mult_c, mult_q;
   logic [CSUM_W-1:0] csum_c, csum_q;
   logic [CSUM_W-1:0] dl [WIN];
   logic [QSUM_W-1:0] qwin_q;
   logic              plane_q;

   // per-channel hit history: a channel is active if it fired in any window slot
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [WIN-1:0] h;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) h <= '0;
         else        h <= {h[WIN-2:0], hit_i[c]};
      end
      assign act[c] = |h;
   end

   always_comb begin
      csum_c = '0;
      for (int i = 0; i < NCH; i++) begin
         if (hit_i[i]) csum_c = csum_c + CSUM_W'(chg_i[i*CW +: CW]);
      end
   end

   always_comb begin
      mult_c = '0;
      for (int i = 0; i < NCH; i++) mult_c = mult_c + CNT_W'(act[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csum_q <= '0;
         mult_q <= '0;
         qwin_q <= '0;
         for (int i = 0; i < WIN; i++) dl[i] <= '0;
      end else begin
         csum_q <= csum_c;
         mult_q <= mult_c;
         qwin_q <= qwin_q + QSUM_W'(csum_q) - QSUM_W'(dl[WIN-1]);
         dl[0]  <= csum_q;
         for (int i = 1; i < WIN; i++) dl[i] <= dl[i-1];
      end
   end

   if (VETO) begin : g_veto
      localparam int NPL  = NCH / PLANE_SZ;
      localparam int PC_W = $clog2(PLANE_SZ + 1);
      logic [NPL-1:0] hot;
      for (genvar p = 0; p < NPL; p++) begin : g_pl
         logic [PC_W-1:0] n;
         always_comb begin
            n = '0;
            for (int i = 0; i < PLANE_SZ; i++) n = n + PC_W'(act[p*PLANE_SZ + i]);
         end
         assign hot[p] = n > PC_W'(PLANE_MIN);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) plane_q <= 1'b0;
         else        plane_q <= |hot;
      end
   end else begin : g_central
      assign plane_q = 1'b0;
   end

   assign mult_o  = mult_q;
   assign qwin_o  = qwin_q;
   assign plane_o = plane_q;

   assert_mult_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mult_q <= CNT_W'(NCH));
   assert_qwin_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      {{(64-QSUM_W){1'b0}}, qwin_q} <= 64'(QMAX));
   assert_quiet_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |=> (mult_q == '0));
endmodule

// File: rtl/mtrig_periodic.sv
module mtrig_periodic #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [PER_W-1:0] period_i,
   output logic             pulse_o
);
   logic [PER_W-1:0] ctr_q;
   logic             pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr_q   <= '0;
         pulse_q <= 1'b0;
      end else if (!en_i) begin
         ctr_q   <= '0;
         pulse_q <= 1'b0;
      end else if ((ctr_q + PER_W'(1)) >= period_i) begin
         ctr_q   <= '0;
         pulse_q <= 1'b1;
      end else begin
         ctr_q   <= ctr_q + PER_W'(1);
         pulse_q <= 1'b0;
      end
   end

   assign pulse_o = pulse_q;

   assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pulse_q);
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (ctr_q == '0));
endmodule

// File: rtl/mtrig_top.sv
module mtrig_top
   import mtrig_pkg::*;
#(
   parameter int NCH       = 256,
   parameter int CW        = 8,
   parameter int WIN       = 4,
   parameter bit VETO      = 1'b0,
   parameter int PLANE_SZ  = 16,
   parameter int PLANE_MIN = 2,
   parameter int DW        = 32,
   parameter int PER_W     = 16,
   parameter int HOLD_W    = 8,
   parameter int MTHR_RST  = 15,
   parameter int QTHR_RST  = 15,
   parameter int PER_RST   = 1000,
   parameter int HOLD_RST  = WIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    hit_i,
   input  logic [NCH*CW-1:0] charge_i,
   input  logic              led_req_i,
   input  logic              src_req_i,
   input  logic              muon_req_i,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_addr_i,
   input  logic [DW-1:0]     cfg_wdata_i,
   output logic              trig_o,
   output logic [4:0]        type_o
);
   localparam int CNT_W  = $clog2(NCH + 1);
   localparam int CSUM_W = CW + $clog2(NCH + 1);
   localparam int QSUM_W = CSUM_W + $clog2(WIN + 1);

   if (WIN < 2) begin : g_bad_win
      $error("mtrig_top: WIN must be at least 2");
   end
   if (WIN >= (1 << HOLD_W)) begin : g_bad_hold
      $error("mtrig_top: HOLD_W too narrow for WIN");
   end
   if (VETO && (NCH % PLANE_SZ != 0)) begin : g_bad_plane
      $error("mtrig_top: NCH must be a multiple of PLANE_SZ");
   end
   if (QSUM_W > DW) begin : g_bad_qsum
      $error("mtrig_top: charge sum wider than DW");
   end

   ctrl_t             ctrl;
   logic [CNT_W-1:0]  mthr, mult;
   logic [QSUM_W-1:0] qthr, qwin;
   logic [PER_W-1:0]  period;
   logic [HOLD_W-1:0] hold_r, hold_eff, hold_q;
   logic              plane, per_pulse, phys_c;
   logic [2:0]        ext_d1, ext_d2;
   logic [TYPE_W-1:0] req_c, type_q;
   logic              trig_q;

   mtrig_cfg #(
      .DW(DW), .CNT_W(CNT_W), .QSUM_W(QSUM_W), .PER_W(PER_W), .HOLD_W(HOLD_W),
      .MTHR_RST(MTHR_RST), .QTHR_RST(QTHR_RST), .PER_RST(PER_RST), .HOLD_RST(HOLD_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
      .ctrl_o(ctrl), .mthr_o(mthr), .qthr_o(qthr), .per_o(period), .hold_o(hold_r)
   );

   mtrig_window #(
      .NCH(NCH), .CW(CW), .WIN(WIN), .CNT_W(CNT_W), .CSUM_W(CSUM_W), .QSUM_W(QSUM_W),
      .VETO(VETO), .PLANE_SZ(PLANE_SZ), .PLANE_MIN(PLANE_MIN)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .chg_i(charge_i),
      .mult_o(mult), .qwin_o(qwin), .plane_o(plane)
   );

   mtrig_periodic #(.PER_W(PER_W)) u_per (
      .clk(clk), .rst_n(rst_n), .en_i(ctrl.per), .period_i(period), .pulse_o(per_pulse)
   );

   // align external requests with the two-stage physics path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_d1 <= '0;
         ext_d2 <= '0;
      end else begin
         ext_d1 <= {muon_req_i, src_req_i, led_req_i};
         ext_d2 <= ext_d1;
      end
   end

   assign phys_c = (ctrl.mult && (mult > mthr)) ||
                   (ctrl.chg  && (qwin > qthr)) ||
                   (ctrl.mult && plane);

   always_comb begin
      req_c          = '0;
      req_c[TB_PHYS] = phys_c;
      req_c[TB_LED]  = ext_d2[0] && ctrl.led;
      req_c[TB_SRC]  = ext_d2[1] && ctrl.src;
      req_c[TB_PER]  = per_pulse;
      req_c[TB_MUON] = ext_d2[2] && ctrl.muon;
   end

   assign hold_eff = (hold_r < HOLD_W'(WIN)) ? HOLD_W'(WIN) : hold_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         type_q <= '0;
         hold_q <= '0;
      end else if (hold_q != '0) begin
         trig_q <= 1'b0;
         type_q <= '0;
         hold_q <= hold_q - HOLD_W'(1);
      end else if (req_c != '0) begin
         trig_q <= 1'b1;
         type_q <= req_c;
         hold_q <= hold_eff;
      end else begin
         trig_q <= 1'b0;
         type_q <= '0;
      end
   end

   assign trig_o = trig_q;
   assign type_o = type_q;

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |=> !trig_q);
   assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q != '0) |=> !trig_q);
   assert_type_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |-> (type_q != '0));
   assert_type_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_q |-> (type_q == '0));
   assert_hold_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q |-> (hold_q >= HOLD_W'(WIN)));
endmodule

// File: tb/tb_mtrig_top.sv
`timescale 1ns/1ps
module tb_mtrig_top;
   localparam int NCH = 256;
   localparam int CW  = 8;
   localparam int VN  = 16;
   localparam int VCW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]    hit = '0;
   logic [NCH*CW-1:0] chg = '0;
   logic            led = 1'b0, src = 1'b0, mu = 1'b0;
   logic            we = 1'b0;
   logic [2:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic            trig_o;
   logic [4:0]      type_o;

   logic [VN-1:0]     vhit = '0;
   logic [VN*VCW-1:0] vchg = '0;
   logic            vtrig;
   logic [4:0]      vtype;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   typedef struct { int cyc; logic [4:0] mask; string tag; } exp_t;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mtrig_top dut (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .charge_i(chg),
      .led_req_i(led), .src_req_i(src), .muon_req_i(mu),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .trig_o(trig_o), .type_o(type_o)
   );

   mtrig_top #(.NCH(VN), .CW(VCW), .VETO(1'b1), .PLANE_SZ(4), .PLANE_MIN(2)) dut_veto (
      .clk(clk), .rst_n(rst_n), .hit_i(vhit), .charge_i(vchg),
      .led_req_i(1'b0), .src_req_i(1'b0), .muon_req_i(1'b0),
      .cfg_we_i(1'b0), .cfg_addr_i(3'd0), .cfg_wdata_i(32'd0),
      .trig_o(vtrig), .type_o(vtype)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   // monitor: compares each pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
            checks++; fails++;
            $display("FAIL %s: actual no pulse expected mask %0d at cycle %0d",
                     exp_q[0].tag, exp_q[0].mask, exp_q[0].cyc);
            void'(exp_q.pop_front());
         end
         if (trig_o) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
               chk(type_o === exp_q[0].mask, exp_q[0].tag, int'(type_o), int'(exp_q[0].mask));
               void'(exp_q.pop_front());
            end else begin
               checks++; fails++;
               $display("FAIL unexpected pulse: actual mask %0d expected none at cycle %0d",
                        type_o, cyc);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      hit = '0; chg = '0; led = 1'b0; src = 1'b0; mu = 1'b0; we = 1'b0; vhit = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) tick();
   endtask

   task automatic put_hits(input int base, input int cnt, input int q);
      for (int i = base; i < base + cnt; i++) begin
         hit[i] = 1'b1;
         chg[i*CW +: CW] = CW'(q);
      end
   endtask

   task automatic expect_at(input int dly, input logic [4:0] m, input string tag);
      exp_t e;
      e.cyc = cyc + dly; e.mask = m; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic cfg(input logic [2:0] a, input int d);
      we = 1'b1; addr = a; wdata = 32'(d);
      tick();
   endtask

   task automatic quiet(input int n, input string tag);
      int seen = 0;
      repeat (n) begin
         tick();
         if (trig_o) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   task automatic veto_case(input logic [VN-1:0] pat, input bit fire, input string tag);
      vhit = pat;
      tick();
      tick();
      chk(vtrig == 1'b0, {tag, " early"}, int'(vtrig), 0);
      tick();
      chk(vtrig == fire, tag, int'(vtrig), int'(fire));
      if (fire) chk(vtype == 5'b00001, {tag, " type"}, int'(vtype), 1);
      idle(10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      tick();
      // R11 reset state
      chk(trig_o == 1'b0, "R11 trig after reset", int'(trig_o), 0);
      chk(type_o == 5'd0, "R11 type after reset", int'(type_o), 0);
      idle(4);

      // R1 multiplicity, strict compare; R5 latency via due cycle
      put_hits(0, 16, 0); expect_at(3, 5'b00001, "R1 R5 sixteen channels"); tick(); idle(10);
      put_hits(0, 15, 0); tick(); quiet(10, "R1 fifteen channels no trigger");

      // R2 charge
      put_hits(0, 2, 8); expect_at(3, 5'b00001, "R2 charge 16"); tick(); idle(10);
      put_hits(0, 1, 15); tick(); quiet(10, "R2 charge 15 no trigger");

      // R3 repeated channel counted once
      put_hits(0, 8, 0); tick(); put_hits(0, 8, 0); tick(); quiet(10, "R3 repeat counted once");
      put_hits(0, 8, 0); tick(); put_hits(8, 8, 0);
      expect_at(3, 5'b00001, "R3 distinct channels combine"); tick(); idle(10);

      // R4 window length
      put_hits(0, 8, 0); idle(4); put_hits(8, 8, 0); tick(); quiet(10, "R4 gap of 4 no combine");
      put_hits(0, 8, 0); idle(3); put_hits(8, 8, 0);
      expect_at(3, 5'b00001, "R4 gap of 3 combines"); tick(); idle(10);
      put_hits(0, 1, 8); idle(3); put_hits(1, 1, 8);
      expect_at(3, 5'b00001, "R4 charge over window"); tick(); idle(10);

      // R6 type tagging
      led = 1'b1; expect_at(3, 5'b00010, "R6 led type"); tick(); idle(10);
      src = 1'b1; expect_at(3, 5'b00100, "R6 source type"); tick(); idle(10);
      mu = 1'b1;  expect_at(3, 5'b10000, "R6 muon type"); tick(); idle(10);
      put_hits(0, 16, 0); led = 1'b1; src = 1'b1; mu = 1'b1;
      expect_at(3, 5'b10111, "R6 coincident mask"); tick(); idle(10);

      // R9 enables
      cfg(3'd0, 32'h2E); idle(2);
      put_hits(0, 16, 0); tick(); quiet(10, "R9 multiplicity disabled");
      cfg(3'd0, 32'h2D); idle(2);
      put_hits(0, 2, 8); tick(); quiet(10, "R9 charge disabled");
      cfg(3'd0, 32'h2B); idle(2);
      led = 1'b1; tick(); quiet(10, "R9 led disabled");
      cfg(3'd0, 32'h27); idle(2);
      src = 1'b1; tick(); quiet(10, "R9 source disabled");
      cfg(3'd0, 32'h0F); idle(2);
      mu = 1'b1; tick(); quiet(10, "R9 muon disabled");
      cfg(3'd0, 32'h2F); idle(4);

      // R7 periodic
      cfg(3'd3, 20); idle(2);
      we = 1'b1; addr = 3'd0; wdata = 32'h3F;
      expect_at(22, 5'b01000, "R7 first periodic");
      expect_at(42, 5'b01000, "R7 second periodic");
      expect_at(62, 5'b01000, "R7 third periodic");
      tick(); idle(64);
      cfg(3'd0, 32'h2F);
      quiet(40, "R9 periodic disabled");

      // R8 holdoff with default length
      led = 1'b1; expect_at(3, 5'b00010, "R8 first led"); idle(2);
      led = 1'b1; idle(4);
      led = 1'b1; expect_at(3, 5'b00010, "R8 after holdoff"); tick(); idle(10);
      // longer holdoff
      cfg(3'd4, 10); idle(2);
      led = 1'b1; expect_at(3, 5'b00010, "R8 long holdoff first"); idle(8);
      led = 1'b1; idle(3);
      led = 1'b1; expect_at(3, 5'b00010, "R8 long holdoff end"); tick(); idle(16);
      // short value is raised to the window length
      cfg(3'd4, 1); idle(2);
      led = 1'b1; expect_at(3, 5'b00010, "R8 clamp first"); idle(4);
      led = 1'b1; tick();
      led = 1'b1; expect_at(3, 5'b00010, "R8 clamp end"); tick(); idle(10);
      cfg(3'd4, 4); idle(2);
      // held request yields separated single pulses
      expect_at(3, 5'b00010, "R8 held request first");
      expect_at(8, 5'b00010, "R8 held request second");
      for (int i = 0; i < 10; i++) begin
         led = 1'b1;
         tick();
      end
      idle(12);

      // R10 veto planes
      veto_case(16'h0070, 1'b1, "R10 three hits in one plane");
      veto_case(16'h3333, 1'b0, "R10 two hits per plane");
      veto_case(16'h7000, 1'b1, "R10 three hits in last plane");

      idle(10);
      chk(exp_q.size() == 0, "R5 all expected pulses seen", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule